// File: doc/BRIEF.md
# Dual-Mode Segment Address Generator

This block turns a segment value and an offset into a linear address for a load, store or fetch. It has two modes, picked for each request by a mode bit. In real mode, the low 16 bits of the segment input are moved up by four bit places and the low 16 bits of the offset are added. The sum keeps its carry, so an address just above 1MB can be reached. In protected mode, a 32-bit segment base is added to a 32-bit offset. A descriptor stage outside this block supplies that base.

In real mode the block also checks that every byte of the access falls inside the 64KB segment window. When an access runs past the end of the window, the block raises a fault and presents the general-protection vector. The address, the fault flag, the vector and the mode of the request are all registered. They appear together one clock after the request strobe.

Top module: `seg_agen_unit`

## Requirements
- R1: During and after a synchronous reset, `res_valid`, `res_fault`, `res_addr` and `res_vector` are all zero. `res_prot` is zero, which means real mode.
- R2: In real mode (`req_prot`=0), `res_addr` equals `req_seg[15:0]`×16 + `req_off[15:0]`, zero-extended to 32 bits. Bits 31:16 of both inputs have no effect.
- R3: The real-mode sum keeps its carry into bit 20. For example, segment 0xFFFF with offset 0xFFFF gives 0x0010FFEF, not a wrapped value.
- R4: The size code `req_size` encodes the access width: 2'b00 means 1 byte, 2'b01 means 2 bytes, and 2'b10 or 2'b11 means 4 bytes. In real mode, `res_fault` is 1 exactly when `req_off[15:0]` + bytes − 1 > 0xFFFF.
- R5: `res_vector` is 13 when `res_fault` is 1, and 0 otherwise.
- R6: In protected mode (`req_prot`=1), `res_addr` equals (`req_seg` + `req_off`) mod 2^32, and `res_fault` is always 0.
- R7: The results for a request appear on the clock edge after the edge that samples `req_valid`=1. `res_valid` is 1 for one cycle per request, and `res_prot` shows that request's mode. Requests on back-to-back cycles each give their own result.
- R8: While `req_valid` is 0, `res_valid` is 0, and `res_addr`, `res_fault`, `res_vector` and `res_prot` keep their last values, whatever the other inputs do.
- R9: A real-mode request with offset 0 gives an address whose bits 3:0 are zero, because segments start on 16-byte boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_prot | input | 1 | Mode: 0 = real, 1 = protected |
| req_seg | input | 32 | Segment value (real mode uses 15:0) or segment base |
| req_off | input | 32 | Offset (real mode uses 15:0) |
| req_size | input | 2 | Access size code |
| res_valid | output | 1 | Result strobe |
| res_prot | output | 1 | Mode of the presented result |
| res_addr | output | 32 | Linear address |
| res_fault | output | 1 | Segment-end fault |
| res_vector | output | 8 | Fault vector (13 or 0) |

## Verification
Every result arrives exactly one cycle after the request: the address, the fault flag, the vector and the mode all come from one register. The bench drives each request on a falling edge. It samples the outputs on the next falling edge, which is half a cycle after the capturing rising edge. Back-to-back requests are checked one cycle apart in the same way. The hold checks wait two further cycles with the strobe low before they sample, so any stray update would already be visible.

// File: rtl/seg_agen_pkg.sv
package seg_agen_pkg;
    localparam int LIN_W  = 32;
    localparam int SEG_W  = 16;
    localparam int OFF_W  = 16;
    localparam int SHIFT  = 4;
    localparam int SIZE_W = 2;
    localparam int VEC_W  = 8;
    localparam int RA_W   = SEG_W + SHIFT + 1;
    localparam logic [VEC_W-1:0] GP_VECTOR = VEC_W'(13);

    typedef enum logic {
        MODE_REAL = 1'b0,
        MODE_PROT = 1'b1
    } mode_e;

    typedef struct packed {
        logic [LIN_W-1:0] addr;
        logic             fault;
    } agen_res_t;

    typedef struct packed {
        logic             valid;
        mode_e            mode;
        logic [LIN_W-1:0] addr;
        logic             fault;
        logic [VEC_W-1:0] vector;
    } agen_out_t;

    // bytes minus one for a size code: 1, 2 or 4 bytes
    function automatic logic [OFF_W:0] span_m1(input logic [SIZE_W-1:0] code);
        case (code)
            2'b00:   return (OFF_W+1)'(0);
            2'b01:   return (OFF_W+1)'(1);
            default: return (OFF_W+1)'(3);
        endcase
    endfunction
endpackage

// File: rtl/seg_agen_real.sv
module seg_agen_real
    import seg_agen_pkg::*;
(
    input  logic [SEG_W-1:0]  seg,
    input  logic [OFF_W-1:0]  off,
    input  logic [SIZE_W-1:0] size,
    output agen_res_t         res
);
    logic [RA_W-1:0]  sum;
    logic [OFF_W:0]   last_byte;
    logic [LIN_W-1:0] addr_ext;

    always_comb begin
        sum       = RA_W'({seg, {SHIFT{1'b0}}}) + RA_W'(off);
        last_byte = {1'b0, off} + span_m1(size);
    end

    generate
        if (LIN_W > RA_W) begin : g_zext
            assign addr_ext = {{(LIN_W-RA_W){1'b0}}, sum};
        end else if (LIN_W == RA_W) begin : g_same
            assign addr_ext = sum;
        end else begin : g_trunc
            assign addr_ext = sum[LIN_W-1:0];
        end
    endgenerate

    always_comb begin
        res.addr  = addr_ext;
        res.fault = last_byte[OFF_W];
    end
endmodule

// File: rtl/seg_agen_prot.sv
module seg_agen_prot
    import seg_agen_pkg::*;
(
    input  logic [LIN_W-1:0] base,
    input  logic [LIN_W-1:0] off,
    output agen_res_t        res
);
    always_comb begin
        res.addr  = base + off;
        res.fault = 1'b0;
    end
endmodule

// File: rtl/seg_agen_outreg.sv
module seg_agen_outreg
    import seg_agen_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      in_valid,
    input  mode_e     in_mode,
    input  agen_res_t in_res,
    output agen_out_t q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (in_valid) begin
            q.valid  <= 1'b1;
            q.mode   <= in_mode;
            q.addr   <= in_res.addr;
            q.fault  <= in_res.fault;
            q.vector <= in_res.fault ? GP_VECTOR : '0;
        end else begin
            q.valid <= 1'b0;
        end
    end
endmodule

// File: rtl/seg_agen_unit.sv
module seg_agen_unit
    import seg_agen_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_prot,
    input  logic [LIN_W-1:0]  req_seg,
    input  logic [LIN_W-1:0]  req_off,
    input  logic [SIZE_W-1:0] req_size,
    output logic              res_valid,
    output logic              res_prot,
    output logic [LIN_W-1:0]  res_addr,
    output logic              res_fault,
    output logic [VEC_W-1:0]  res_vector
);
    agen_res_t real_res;
    agen_res_t prot_res;
    agen_res_t sel_res;
    mode_e     mode;
    agen_out_t q;

    assign mode = mode_e'(req_prot);

    seg_agen_real u_real (
        .seg  (req_seg[SEG_W-1:0]),
        .off  (req_off[OFF_W-1:0]),
        .size (req_size),
        .res  (real_res)
    );

    seg_agen_prot u_prot (
        .base (req_seg),
        .off  (req_off),
        .res  (prot_res)
    );

    always_comb begin
        sel_res = (mode == MODE_PROT) ? prot_res : real_res;
    end

    seg_agen_outreg u_out (
        .clk      (clk),
        .rst      (rst),
        .in_valid (req_valid),
        .in_mode  (mode),
        .in_res   (sel_res),
        .q        (q)
    );

    assign res_valid  = q.valid;
    assign res_prot   = q.mode;
    assign res_addr   = q.addr;
    assign res_fault  = q.fault;
    assign res_vector = q.vector;
endmodule

// File: rtl/seg_agen_unit_chk.sv
module seg_agen_unit_chk
    import seg_agen_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_prot,
    input logic [LIN_W-1:0]  req_seg,
    input logic [LIN_W-1:0]  req_off,
    input logic [SIZE_W-1:0] req_size,
    input logic              res_valid,
    input logic              res_prot,
    input logic [LIN_W-1:0]  res_addr,
    input logic              res_fault,
    input logic [VEC_W-1:0]  res_vector
);
    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> (!res_valid && !res_prot && !res_fault)); // R1
    AST_REAL_ADDR: assert property (@(posedge clk) disable iff (rst) (req_valid && !req_prot) |=> res_addr == (LIN_W'({$past(req_seg[SEG_W-1:0]), {SHIFT{1'b0}}}) + LIN_W'($past(req_off[OFF_W-1:0])))); // R2
    AST_REAL_CEILING: assert property (@(posedge clk) disable iff (rst) (res_valid && !res_prot) |-> res_addr <= LIN_W'(32'h0010_FFEF)); // R3
    AST_FAULT_VECTOR: assert property (@(posedge clk) disable iff (rst) res_valid |-> (res_vector == (res_fault ? GP_VECTOR : '0))); // R5
    AST_PROT_NO_FAULT: assert property (@(posedge clk) disable iff (rst) (res_valid && res_prot) |-> !res_fault); // R6
    AST_PROT_ADDR: assert property (@(posedge clk) disable iff (rst) (req_valid && req_prot) |=> res_addr == ($past(req_seg) + $past(req_off))); // R6
    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) req_valid |=> (res_valid && res_prot == $past(req_prot))); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) !req_valid |=> (!res_valid && $stable(res_addr) && $stable(res_fault) && $stable(res_prot))); // R8
endmodule

bind seg_agen_unit seg_agen_unit_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_prot   (req_prot),
    .req_seg    (req_seg),
    .req_off    (req_off),
    .req_size   (req_size),
    .res_valid  (res_valid),
    .res_prot   (res_prot),
    .res_addr   (res_addr),
    .res_fault  (res_fault),
    .res_vector (res_vector)
);

// File: tb/tb_seg_agen_unit.sv
module tb_seg_agen_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_prot = 1'b0;
    logic [31:0] req_seg = '0;
    logic [31:0] req_off = '0;
    logic [1:0]  req_size = '0;
    logic        res_valid;
    logic        res_prot;
    logic [31:0] res_addr;
    logic        res_fault;
    logic [7:0]  res_vector;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #10 clk = ~clk;

    seg_agen_unit dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_prot(req_prot),
        .req_seg(req_seg), .req_off(req_off), .req_size(req_size),
        .res_valid(res_valid), .res_prot(res_prot), .res_addr(res_addr),
        .res_fault(res_fault), .res_vector(res_vector)
    );

    typedef struct packed {
        logic        prot;
        logic [31:0] seg;
        logic [31:0] off;
        logic [1:0]  size;
        logic [31:0] exp_addr;
        logic        exp_fault;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VT [NV] = '{
        '{1'b0, 32'h0000_1234, 32'h0000_0010, 2'b00, 32'h0001_2350, 1'b0},
        '{1'b0, 32'h0000_FFFF, 32'h0000_FFFF, 2'b00, 32'h0010_FFEF, 1'b0},
        '{1'b0, 32'h0000_0000, 32'h0000_FFFF, 2'b01, 32'h0000_FFFF, 1'b1},
        '{1'b0, 32'h0000_0000, 32'h0000_FFFE, 2'b01, 32'h0000_FFFE, 1'b0},
        '{1'b0, 32'h0000_1000, 32'h0000_FFFC, 2'b10, 32'h0001_FFFC, 1'b0},
        '{1'b0, 32'h0000_1000, 32'h0000_FFFD, 2'b10, 32'h0001_FFFD, 1'b1},
        '{1'b0, 32'hABCD_0100, 32'hFFFF_0002, 2'b00, 32'h0000_1002, 1'b0},
        '{1'b0, 32'h0000_0000, 32'h0000_FFFD, 2'b11, 32'h0000_FFFD, 1'b1},
        '{1'b0, 32'h0000_0000, 32'h0000_FFFF, 2'b00, 32'h0000_FFFF, 1'b0},
        '{1'b1, 32'h0010_0000, 32'h0000_1234, 2'b10, 32'h0010_1234, 1'b0},
        '{1'b1, 32'hFFFF_FFF0, 32'h0000_0020, 2'b10, 32'h0000_0010, 1'b0},
        '{1'b1, 32'h0000_0000, 32'hFFFF_FFFF, 2'b10, 32'hFFFF_FFFF, 1'b0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        req_valid = 1'b1;
        req_prot  = v.prot;
        req_seg   = v.seg;
        req_off   = v.off;
        req_size  = v.size;
    endtask

    task automatic check_result(input vec_t v);
        string tag;
        tag = v.prot ? "R6 prot addr" : (v.exp_fault ? "R4 real limit" : "R2/R3 real addr");
        check(tag, res_addr, v.exp_addr);
        check(v.prot ? "R6 no fault" : "R4 fault", 32'(res_fault), 32'(v.exp_fault));
        check("R5 vector", 32'(res_vector), v.exp_fault ? 32'd13 : 32'd0);
        check("R7 valid", 32'(res_valid), 32'd1);
        check("R7 mode", 32'(res_prot), 32'(v.prot));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (4000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        vec_t a;
        vec_t b;
        logic [31:0] held;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 valid", 32'(res_valid), 32'd0);
        check("R1 prot", 32'(res_prot), 32'd0);
        check("R1 addr", res_addr, 32'd0);
        check("R1 fault", 32'(res_fault), 32'd0);
        check("R1 vector", 32'(res_vector), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 idle after reset", 32'(res_valid), 32'd0);

        // vector table
        for (int i = 0; i < NV; i++) begin
            drive(VT[i]);
            @(negedge clk);
            req_valid = 1'b0;
            check_result(VT[i]);
        end

        // R8: idle with changing inputs holds outputs
        held = res_addr;
        req_prot = 1'b0;
        req_seg  = 32'h0000_7777;
        req_off  = 32'h0000_FFFF;
        req_size = 2'b10;
        repeat (2) @(negedge clk);
        check("R8 addr hold", res_addr, held);
        check("R8 valid low", 32'(res_valid), 32'd0);
        check("R8 fault hold", 32'(res_fault), 32'd0);
        check("R8 prot hold", 32'(res_prot), 32'd1);

        // R9: 16-byte alignment of segment start
        drive('{1'b0, 32'h0000_0ABC, 32'h0, 2'b00, 32'h0000_ABC0, 1'b0});
        @(negedge clk);
        req_valid = 1'b0;
        check("R9 align", 32'(res_addr[3:0]), 32'd0);
        check("R9 addr", res_addr, 32'h0000_ABC0);

        // R7: back-to-back requests, mixed modes
        a = '{1'b1, 32'h8000_0000, 32'h0000_0004, 2'b01, 32'h8000_0004, 1'b0};
        b = '{1'b0, 32'h0000_0001, 32'h0000_FFFF, 2'b10, 32'h0001_000F, 1'b1};
        drive(a);
        @(negedge clk);
        drive(b);
        check_result(a);
        @(negedge clk);
        req_valid = 1'b0;
        check_result(b);
        @(negedge clk);
        check("R7 single pulse", 32'(res_valid), 32'd0);

        // R1: reset in mid-run returns to real mode
        drive(a);
        @(negedge clk);
        req_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        check("R1 rerst prot", 32'(res_prot), 32'd0);
        check("R1 rerst addr", res_addr, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        finish_run();
    end
endmodule